// File: doc/BRIEF.md
# Conditional Flow Next-PC Unit

This block works out where a two-stage pipelined core fetches next after a conditional flow-control instruction. Each request gives the address of the current instruction, the 8-bit status register, a flag selector with a polarity, a relative displacement, a precomputed skip condition, and whether the word that follows is the first half of a two-word instruction. The block returns three things: the next program counter, whether control flow left the sequential path, and how many cycles the instruction occupies.

Conditional branches test one chosen status bit for either value. Every named branch (equal, carry, minus, half carry, T, overflow, interrupt-enabled and the others) maps onto that single test. Signed comparisons use their own mode, which evaluates N xor V directly. Skip instructions jump over one or two words. The unconditional relative jump uses a wider displacement that reaches the whole program space. The result is registered and appears one clock after the request. Fetch, decode and the call/return stack sit outside this block.

Top module: `nxpc_unit`

## Requirements
- R1: While `rst` is high, and after it until the first request, `out_valid`, `next_pc`, `taken` and `cycles` are all zero.
- R2: For `req_op`=1 (flag branch), the branch is taken when `status[flag_sel]` equals `flag_pol`. When taken, `next_pc` is `cur_pc` + sign-extended `offset[6:0]` + 1. When not taken, `next_pc` is `cur_pc` + 1. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R3: For `req_op`=2 (signed compare branch), the condition is status[2] xor status[3], compared with `flag_pol`. The stored bit 4 and `flag_sel` have no effect. The target is the same as in R2.
- R4: For `req_op`=3 (skip), `skip_hit`=0 gives `cur_pc`+1. `skip_hit`=1 gives `cur_pc`+2 when `skip_two_word`=0 and `cur_pc`+3 when it is 1. `taken` equals `skip_hit`.
- R5: For `req_op`=4 (relative jump), `next_pc` is `cur_pc` + `offset` (all 12 bits, two's complement) + 1, `taken`=1 and `cycles`=2.
- R6: A flag or signed branch reports `cycles`=2 when taken and 1 when not taken.
- R7: A skip reports `cycles`=1 with no skip, 2 when skipping one word and 3 when skipping two words.
- R8: All program counter arithmetic wraps modulo 4096.
- R9: `out_valid` is high exactly one clock after a cycle with `req_valid` high. In a cycle after one without a request, `out_valid` is 0 and `next_pc`, `taken` and `cycles` keep their values.
- R10: For branch modes, `offset[11:7]` has no effect on the result.
- R11: `req_op` values 0, 5, 6 and 7 give `cur_pc`+1, `taken`=0 and `cycles`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation: 1 flag branch, 2 signed branch, 3 skip, 4 relative jump, other values sequential |
| cur_pc | input | 12 | Word address of the current instruction |
| status | input | 8 | Status register |
| flag_sel | input | 3 | Status bit tested by a flag branch |
| flag_pol | input | 1 | Value of the condition that takes the branch |
| offset | input | 12 | Displacement: low 7 bits for branches, all 12 bits for a jump |
| skip_hit | input | 1 | Skip condition holds |
| skip_two_word | input | 1 | The instruction being skipped is two words long |
| out_valid | output | 1 | Result registers hold a new result |
| next_pc | output | 12 | Next program counter |
| taken | output | 1 | Flow left the sequential path |
| cycles | output | 2 | Cycles the instruction consumes |

## Verification
Two functions can land in the same cycle: the flag condition deciding to take a branch, and the target adder wrapping past either end of the 4K space. Both change `next_pc` at once. The bench provokes this by placing the current address within a displacement of 0 or 4095 while sweeping every status value against both polarities, so a taken branch there must wrap and a not-taken one must not. It also drives skips over two-word instructions at address 4093 and beyond. Each registered result is compared on the following clock with a behavioural reference that works in unbounded integers and reduces modulo 4096 only at the end.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

  typedef enum logic [2:0] {
    OP_SEQ    = 3'd0,
    OP_FLAG   = 3'd1,
    OP_SIGNED = 3'd2,
    OP_SKIP   = 3'd3,
    OP_JUMP   = 3'd4
  } flow_op_e;

  // status bit positions used by the signed comparison
  localparam int unsigned BIT_NEG = 2;
  localparam int unsigned BIT_OVF = 3;

  // which candidate address is selected
  typedef enum logic [1:0] {
    STEP_ONE   = 2'd0,
    STEP_TWO   = 2'd1,
    STEP_THREE = 2'd2,
    STEP_REL   = 2'd3
  } step_e;

  typedef struct packed {
    logic       hit;
    logic [1:0] cyc;
    step_e      step;
  } outcome_t;

endpackage

// File: rtl/nxpc_cond.sv
module nxpc_cond
  import nxpc_pkg::*;
#(
  parameter int SREG_W = 8,
  localparam int SEL_W = (SREG_W > 1) ? $clog2(SREG_W) : 1
) (
  input  logic [2:0]        op,
  input  logic [SREG_W-1:0] status,
  input  logic [SEL_W-1:0]  flag_sel,
  input  logic              flag_pol,
  input  logic              skip_hit,
  input  logic              skip_two_word,
  output outcome_t          result
);

  logic bit_val;
  logic nv_val;
  logic flag_ok;
  logic sign_ok;

  always_comb begin
    bit_val = status[flag_sel];
    nv_val  = status[BIT_NEG] ^ status[BIT_OVF];
    flag_ok = (bit_val == flag_pol);
    sign_ok = (nv_val == flag_pol);
  end

  always_comb begin
    result.hit  = 1'b0;
    result.cyc  = 2'd1;
    result.step = STEP_ONE;
    case (op)
      3'(OP_FLAG): begin
        result.hit  = flag_ok;
        result.cyc  = flag_ok ? 2'd2 : 2'd1;
        result.step = flag_ok ? STEP_REL : STEP_ONE;
      end
      3'(OP_SIGNED): begin
        result.hit  = sign_ok;
        result.cyc  = sign_ok ? 2'd2 : 2'd1;
        result.step = sign_ok ? STEP_REL : STEP_ONE;
      end
      3'(OP_SKIP): begin
        result.hit = skip_hit;
        if (!skip_hit) begin
          result.cyc  = 2'd1;
          result.step = STEP_ONE;
        end else if (skip_two_word) begin
          result.cyc  = 2'd3;
          result.step = STEP_THREE;
        end else begin
          result.cyc  = 2'd2;
          result.step = STEP_TWO;
        end
      end
      3'(OP_JUMP): begin
        result.hit  = 1'b1;
        result.cyc  = 2'd2;
        result.step = STEP_REL;
      end
      default: begin
        result.hit  = 1'b0;
        result.cyc  = 2'd1;
        result.step = STEP_ONE;
      end
    endcase
  end

endmodule

// File: rtl/nxpc_addr.sv
module nxpc_addr
  import nxpc_pkg::*;
#(
  parameter int PC_W     = 12,
  parameter int BR_OFF_W = 7,
  localparam int EXT_W   = PC_W - BR_OFF_W,
  localparam int N_SEQ   = 3
) (
  input  logic [2:0]      op,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PC_W-1:0] offset,
  input  step_e           step,
  output logic [PC_W-1:0] addr
);

  logic [PC_W-1:0] br_disp;
  logic [PC_W-1:0] disp;
  logic [PC_W-1:0] rel_addr;
  logic [PC_W-1:0] seq_addr [N_SEQ];

  // branch displacement: sign-extend the short field, or keep it if it fills the PC
  generate
    if (EXT_W > 0) begin : g_sext
      assign br_disp = {{EXT_W{offset[BR_OFF_W-1]}}, offset[BR_OFF_W-1:0]};
    end else begin : g_full
      assign br_disp = offset;
    end
  endgenerate

  // sequential candidates cur_pc+1 .. cur_pc+N_SEQ, all in parallel
  generate
    for (genvar i = 0; i < N_SEQ; i++) begin : g_seq
      assign seq_addr[i] = cur_pc + PC_W'(i + 1);
    end
  endgenerate

  always_comb begin
    disp     = (op == 3'(OP_JUMP)) ? offset : br_disp;
    rel_addr = cur_pc + disp + PC_W'(1);
  end

  always_comb begin
    case (step)
      STEP_ONE:   addr = seq_addr[0];
      STEP_TWO:   addr = seq_addr[1];
      STEP_THREE: addr = seq_addr[2];
      default:    addr = rel_addr;
    endcase
  end

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int PC_W     = 12,
  parameter int BR_OFF_W = 7,
  parameter int SREG_W   = 8,
  localparam int SEL_W   = (SREG_W > 1) ? $clog2(SREG_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [SREG_W-1:0] status,
  input  logic [SEL_W-1:0]  flag_sel,
  input  logic              flag_pol,
  input  logic [PC_W-1:0]   offset,
  input  logic              skip_hit,
  input  logic              skip_two_word,
  output logic              out_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic [1:0]        cycles
);

  outcome_t        outc;
  logic [PC_W-1:0] addr;

  nxpc_cond #(.SREG_W(SREG_W)) i_cond (
    .op            (req_op),
    .status        (status),
    .flag_sel      (flag_sel),
    .flag_pol      (flag_pol),
    .skip_hit      (skip_hit),
    .skip_two_word (skip_two_word),
    .result        (outc)
  );

  nxpc_addr #(.PC_W(PC_W), .BR_OFF_W(BR_OFF_W)) i_addr (
    .op     (req_op),
    .cur_pc (cur_pc),
    .offset (offset),
    .step   (outc.step),
    .addr   (addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      cycles    <= 2'd0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        next_pc <= addr;
        taken   <= outc.hit;
        cycles  <= outc.cyc;
      end
    end
  end

endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk
  import nxpc_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int SREG_W = 8,
  localparam int SEL_W = (SREG_W > 1) ? $clog2(SREG_W) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [PC_W-1:0]   cur_pc,
  input logic [SREG_W-1:0] status,
  input logic [SEL_W-1:0]  flag_sel,
  input logic              flag_pol,
  input logic              skip_hit,
  input logic              skip_two_word,
  input logic              out_valid,
  input logic [PC_W-1:0]   next_pc,
  input logic              taken,
  input logic [1:0]        cycles
);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) req_valid |=> out_valid); // R9
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !out_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !req_valid |=> $stable(next_pc) && $stable(cycles)); // R9
  AST_FLAG_TAKEN: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'(OP_FLAG) && status[flag_sel] == flag_pol |=> taken && cycles == 2'd2); // R2
  AST_NOT_TAKEN_ONE: assert property (@(posedge clk) disable iff (rst) out_valid && !taken |-> cycles == 2'd1); // R6
  AST_JUMP_TWO: assert property (@(posedge clk) disable iff (rst) req_valid && req_op == 3'(OP_JUMP) |=> taken && cycles == 2'd2); // R5
  AST_SKIP_TWO_WORD: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'(OP_SKIP) && skip_hit && skip_two_word |=> cycles == 2'd3 && next_pc == $past(cur_pc) + PC_W'(3)); // R7
  AST_SIGNED_RULE: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'(OP_SIGNED) |=> taken == ($past(status[BIT_NEG] ^ status[BIT_OVF]) == $past(flag_pol))); // R3
  AST_NO_SKIP_SEQ: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'(OP_SKIP) && !skip_hit |=> !taken && next_pc == $past(cur_pc) + PC_W'(1)); // R4

endmodule

bind nxpc_unit nxpc_unit_chk #(.PC_W(PC_W), .SREG_W(SREG_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_op        (req_op),
  .cur_pc        (cur_pc),
  .status        (status),
  .flag_sel      (flag_sel),
  .flag_pol      (flag_pol),
  .skip_hit      (skip_hit),
  .skip_two_word (skip_two_word),
  .out_valid     (out_valid),
  .next_pc       (next_pc),
  .taken         (taken),
  .cycles        (cycles)
);

// File: tb/test_nxpc_unit.sv
module test_nxpc_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [11:0] cur_pc = '0;
  logic [7:0]  status = '0;
  logic [2:0]  flag_sel = '0;
  logic        flag_pol = 1'b0;
  logic [11:0] offset = '0;
  logic        skip_hit = 1'b0;
  logic        skip_two_word = 1'b0;
  logic        out_valid;
  logic [11:0] next_pc;
  logic        taken;
  logic [1:0]  cycles;

  int total = 0;
  int bad = 0;

  // expected registered outputs
  logic        e_valid = 1'b0;
  int          e_pc = 0;
  logic        e_taken = 1'b0;
  int          e_cyc = 0;
  string       e_tag = "R1";

  always #2.5 clk = ~clk;

  nxpc_unit i_nxpc_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .cur_pc(cur_pc),
    .status(status), .flag_sel(flag_sel), .flag_pol(flag_pol), .offset(offset),
    .skip_hit(skip_hit), .skip_two_word(skip_two_word), .out_valid(out_valid),
    .next_pc(next_pc), .taken(taken), .cycles(cycles)
  );

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  // behavioural reference on plain integers
  task automatic model(input int op, input int pc, input int sr, input int sel, input int pol,
                       input int k, input int sh, input int two,
                       output int npc, output logic tk, output int cyc);
    int raw;
    int disp;
    int cond;
    disp = k % 128;
    if (disp >= 64) disp -= 128;
    npc = pc + 1; tk = 0; cyc = 1;
    if (op == 1 || op == 2) begin
      if (op == 1) cond = (sr >> sel) % 2;
      else cond = ((sr >> 2) % 2) ^ ((sr >> 3) % 2);
      if (cond == pol) begin
        npc = pc + disp + 1; tk = 1; cyc = 2;
      end
    end else if (op == 3) begin
      if (sh != 0) begin
        tk = 1;
        npc = pc + ((two != 0) ? 3 : 2);
        cyc = (two != 0) ? 3 : 2;
      end
    end else if (op == 4) begin
      raw = (k >= 2048) ? k - 4096 : k;
      npc = pc + raw + 1; tk = 1; cyc = 2;
    end
    npc = ((npc % 4096) + 4096) % 4096;
  endtask

  task automatic compare();
    total++;
    if (out_valid !== e_valid || int'(next_pc) != e_pc || taken !== e_taken || int'(cycles) != e_cyc) begin
      bad++;
      $display("FAIL %s: got valid=%0b pc=%0d taken=%0b cyc=%0d exp valid=%0b pc=%0d taken=%0b cyc=%0d",
               e_tag, out_valid, next_pc, taken, cycles, e_valid, e_pc, e_taken, e_cyc);
    end
  endtask

  // at a falling edge: judge the previous cycle, then present the next one
  task automatic issue(input logic v, input int op, input int pc, input int sr, input int sel,
                       input int pol, input int k, input int sh, input int two, input string tag);
    int npc; logic tk; int cyc;
    @(negedge clk);
    compare();
    req_valid = v; req_op = 3'(op); cur_pc = 12'(pc); status = 8'(sr); flag_sel = 3'(sel);
    flag_pol = 1'(pol); offset = 12'(k); skip_hit = 1'(sh); skip_two_word = 1'(two);
    e_valid = v;
    e_tag = v ? tag : "R9";
    if (v) begin
      model(op, pc, sr, sel, pol, k, sh, two, npc, tk, cyc);
      e_pc = npc; e_taken = tk; e_cyc = cyc;
    end
  endtask

  initial begin
    // R1: reset state, with requests presented during reset
    req_valid = 1'b1; req_op = 3'd4; offset = 12'd100;
    repeat (3) @(negedge clk);
    e_tag = "R1"; compare();
    rst = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    e_tag = "R1"; compare();
    e_tag = "R9";

    // R2 / R6: every status value, every flag, both polarities
    for (int sr = 0; sr < 256; sr++)
      for (int sel = 0; sel < 8; sel++)
        for (int pol = 0; pol < 2; pol++)
          issue(1, 1, $urandom_range(0, 4095), sr, sel, pol, $urandom_range(0, 4095), 0, 0, "R2");

    // R3 / R6: signed compare across all status values
    for (int sr = 0; sr < 256; sr++)
      for (int pol = 0; pol < 2; pol++)
        issue(1, 2, $urandom_range(0, 4095), sr, $urandom_range(0, 7), pol, $urandom_range(0, 127), 0, 0, "R3");

    // R9: idle gap keeps values, out_valid drops
    issue(0, 4, 1, 0, 0, 0, 0, 0, 0, "R9");
    issue(0, 1, 7, 255, 0, 1, 5, 0, 0, "R9");

    // R4 / R7: all skip combinations, including wrap at the top
    for (int pc = 4090; pc < 4096; pc++)
      for (int sh = 0; sh < 2; sh++)
        for (int two = 0; two < 2; two++)
          issue(1, 3, pc, $urandom_range(0, 255), 0, 0, 0, sh, two, "R7");
    issue(1, 3, 100, 0, 0, 0, 0, 1, 1, "R4");
    issue(1, 3, 100, 0, 0, 0, 0, 1, 0, "R4");

    // R5: relative jumps, extremes of the displacement
    issue(1, 4, 10, 0, 0, 0, 2047, 0, 0, "R5");
    issue(1, 4, 10, 0, 0, 0, 2048, 0, 0, "R5");
    issue(1, 4, 4095, 0, 0, 0, 0, 0, 0, "R5");
    for (int n = 0; n < 20; n++)
      issue(1, 4, $urandom_range(0, 4095), 0, 0, 0, $urandom_range(0, 4095), 0, 0, "R5");

    // R8: taken branches across both ends of the space
    for (int sr = 0; sr < 256; sr++) begin
      issue(1, 1, 4095 - (sr % 64), sr, 0, 1, 63, 0, 0, "R8");
      issue(1, 1, sr % 64, sr, 1, 0, 64, 0, 0, "R8");
    end

    // R10: upper offset bits must not matter for branches
    issue(1, 1, 200, 8'h01, 0, 1, 12'hF85, 0, 0, "R10");
    issue(1, 1, 200, 8'h01, 0, 1, 12'h005, 0, 0, "R10");
    issue(1, 2, 300, 8'h04, 0, 1, 12'hA7F, 0, 0, "R10");

    // R11: non-flow operation codes
    for (int op = 5; op < 8; op++)
      issue(1, op, 4095, 255, 7, 1, 100, 1, 1, "R11");
    issue(1, 0, 50, 255, 7, 1, 100, 1, 1, "R11");

    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    finish_run();
  end

endmodule